// File: doc/BRIEF.md
# Restricted-Port Integer Issue Queue

This block buffers decoded integer operations between rename and two integer execution units, and sends them to those units out of order. Each operation carries an operation class, two physical source tags, a physical destination tag and an identifier that follows it down the execution pipeline. Up to four operations arrive per cycle, and each is placed in any empty slot of a 16-entry pool. Slots have no age order. Each slot watches three result-tag broadcasts and marks a source operand ready when its tag is seen.

Every cycle the queue picks at most one ready operation for each unit. Operations that branch or shift may only go to unit 1. Operations that multiply or divide may only go to unit 2. Plain arithmetic and logic may go to either unit. A slot is released on the clock edge at which its operation issues. A flush empties the whole pool in one cycle.

Each slot is a two-state machine with the states ENT_FREE and ENT_HELD. It has these transitions:
- ALLOC takes ENT_FREE to ENT_HELD when an accepted dispatch lane writes the slot.
- ISSUE takes ENT_HELD to ENT_FREE when the slot is picked.
- FLUSH takes ENT_HELD to ENT_FREE on a flush.
- In every other cycle the slot holds its state.

Top module: `int_issue_queue`

## Requirements
- R1: After reset all 16 slots are free: `free_cnt` is 16 and neither issue port is valid.
- R2: `free_cnt` is the number of free slots. Accepted lanes 0..`disp_num`-1 are written into the lowest-indexed free slots, lane 0 into the lowest. Slots freed by issue in the same cycle are not reused until the next cycle.
- R3: `disp_accept` is 1 exactly when `flush` is 0 and `disp_num` <= `free_cnt`. When it is 0, no lane is written.
- R4: An operation dispatched with both sources marked ready can issue in the cycle after dispatch.
- R5: A source becomes ready when any valid broadcast `wb_tag` slot k (bits 6k+5..6k) equals its tag. The broadcast may come while the operation is already held, or in its dispatch cycle. The operation can issue in the following cycle.
- R6: Class 1 (branch) and class 2 (shift) issue only on unit 1.
- R7: Class 3 (multiply/divide) issues only on unit 2. Class 0 (plain ALU) may issue on either unit.
- R8: Unit 1 takes the lowest-indexed ready slot legal for it. Unit 2 then takes the lowest-indexed ready slot legal for it among those that remain.
- R9: At most one operation issues per unit per cycle. An issuing slot is free in the next cycle.
- R10: An issue port presents the issuing operation's class, source tags, destination tag and identifier unchanged.
- R11: A flush frees every slot at the next edge. During the flush cycle, no issue port is valid and dispatch is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty every slot |
| disp_num | input | 3 | Number of lanes offered (0..4), starting at lane 0 |
| disp_cls | input | 8 | Class per lane, 2 bits each: 0 ALU, 1 branch, 2 shift, 3 mul/div |
| disp_src1 | input | 24 | First source tag per lane, 6 bits each |
| disp_src2 | input | 24 | Second source tag per lane |
| disp_rdy1 | input | 4 | First source already ready, per lane |
| disp_rdy2 | input | 4 | Second source already ready, per lane |
| disp_dst | input | 24 | Destination tag per lane |
| disp_id | input | 20 | Pipeline identifier per lane, 5 bits each |
| disp_accept | output | 1 | Offered lanes are taken this cycle |
| free_cnt | output | 5 | Number of free slots |
| wb_valid | input | 3 | Broadcast valid per result bus |
| wb_tag | input | 18 | Broadcast tag per result bus, 6 bits each |
| iss1_valid | output | 1 | Unit 1 issue valid |
| iss1_cls | output | 2 | Unit 1 operation class |
| iss1_src1 | output | 6 | Unit 1 first source tag |
| iss1_src2 | output | 6 | Unit 1 second source tag |
| iss1_dst | output | 6 | Unit 1 destination tag |
| iss1_id | output | 5 | Unit 1 identifier |
| iss2_valid | output | 1 | Unit 2 issue valid |
| iss2_cls | output | 2 | Unit 2 operation class |
| iss2_src1 | output | 6 | Unit 2 first source tag |
| iss2_src2 | output | 6 | Unit 2 second source tag |
| iss2_dst | output | 6 | Unit 2 destination tag |
| iss2_id | output | 5 | Unit 2 identifier |

## Verification
The hardest case to reach is a full pool that drains two per cycle through both units at once. Reaching it needs sixteen waiting operations that a single broadcast wakes together. The bench fills the pool with operations that all wait on one shared tag. It then offers one more operation to see the refusal, broadcasts the tag, and follows the drain through the free count. Random traffic with a small tag range then gives frequent wakeups in the dispatch cycle, conflicts between classes for the same slot index, and flushes that land while dispatches are pending.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int TAG_W = 6;
    localparam int ID_W  = 5;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'd0,
        CLS_BRANCH = 2'd1,
        CLS_SHIFT  = 2'd2,
        CLS_MULDIV = 2'd3
    } op_cls_e;

    typedef struct packed {
        op_cls_e          cls;
        logic [TAG_W-1:0] src1;
        logic [TAG_W-1:0] src2;
        logic [TAG_W-1:0] dst;
        logic [ID_W-1:0]  id;
    } iq_op_t;

    typedef enum logic {
        ENT_FREE = 1'b0,
        ENT_HELD = 1'b1
    } ent_state_e;
endpackage

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int WB = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wr_en,
    input  iq_op_t              wr_op,
    input  logic                wr_rdy1,
    input  logic                wr_rdy2,
    input  logic [WB-1:0]       wb_valid,
    input  logic [WB*TAG_W-1:0] wb_tag,
    input  logic                issue,
    output logic                is_free,
    output logic                is_ready,
    output iq_op_t              op_q
);
    ent_state_e state, state_nxt;
    logic       rdy1_q, rdy2_q;

    function automatic logic tag_hit(input logic [TAG_W-1:0] t);
        logic h;
        h = 1'b0;
        for (int k = 0; k < WB; k++)
            if (wb_valid[k] && wb_tag[k*TAG_W +: TAG_W] == t) h = 1'b1;
        return h;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENT_FREE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ENT_FREE: if (wr_en && !flush)  state_nxt = ENT_HELD;
            ENT_HELD: if (flush || issue)   state_nxt = ENT_FREE;
            default:                        state_nxt = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            rdy1_q <= 1'b0;
            rdy2_q <= 1'b0;
        end else if (wr_en) begin
            op_q   <= wr_op;
            rdy1_q <= wr_rdy1 | tag_hit(wr_op.src1);
            rdy2_q <= wr_rdy2 | tag_hit(wr_op.src2);
        end else if (state == ENT_HELD) begin
            rdy1_q <= rdy1_q | tag_hit(op_q.src1);
            rdy2_q <= rdy2_q | tag_hit(op_q.src2);
        end
    end

    assign is_free  = (state == ENT_FREE);
    assign is_ready = (state == ENT_HELD) && rdy1_q && rdy2_q;

    AST_WRITE_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> state == ENT_FREE); // R2
    AST_FREED_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> state == ENT_FREE); // R9
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int DEPTH = 16,
    parameter int LANES = 4
) (
    input  logic [DEPTH-1:0]            free_mask,
    output logic [LANES-1:0][DEPTH-1:0] grant
);
    logic [DEPTH-1:0] avail;
    logic             found;

    always_comb begin
        avail = free_mask;
        grant = '0;
        for (int l = 0; l < LANES; l++) begin
            found = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                if (avail[i] && !found) begin
                    grant[l][i] = 1'b1;
                    found       = 1'b1;
                end
            end
            avail = avail & ~grant[l];
        end
    end
endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEPTH-1:0]   ready,
    input  logic [2*DEPTH-1:0] cls,
    output logic [DEPTH-1:0]   pick1,
    output logic [DEPTH-1:0]   pick2
);
    logic [DEPTH-1:0] legal1, legal2;
    logic             found1, found2;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            legal1[i] = ready[i] && (op_cls_e'(cls[2*i +: 2]) != CLS_MULDIV);
            legal2[i] = ready[i] && (op_cls_e'(cls[2*i +: 2]) != CLS_BRANCH)
                                 && (op_cls_e'(cls[2*i +: 2]) != CLS_SHIFT);
        end
        pick1  = '0;
        pick2  = '0;
        found1 = 1'b0;
        found2 = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (legal1[i] && !found1) begin
                pick1[i] = 1'b1;
                found1   = 1'b1;
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (legal2[i] && !pick1[i] && !found2) begin
                pick2[i] = 1'b1;
                found2   = 1'b1;
            end
        end
    end

    AST_ONE_PER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick1) && $onehot0(pick2) && ((pick1 & pick2) == '0)); // R9
endmodule

// File: rtl/int_issue_queue.sv
module int_issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LANES    = 4,
    parameter int WB_PORTS = 3,
    localparam int NUM_W   = $clog2(LANES + 1),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic [NUM_W-1:0]          disp_num,
    input  logic [2*LANES-1:0]        disp_cls,
    input  logic [TAG_W*LANES-1:0]    disp_src1,
    input  logic [TAG_W*LANES-1:0]    disp_src2,
    input  logic [LANES-1:0]          disp_rdy1,
    input  logic [LANES-1:0]          disp_rdy2,
    input  logic [TAG_W*LANES-1:0]    disp_dst,
    input  logic [ID_W*LANES-1:0]     disp_id,
    output logic                      disp_accept,
    output logic [CNT_W-1:0]          free_cnt,
    input  logic [WB_PORTS-1:0]       wb_valid,
    input  logic [TAG_W*WB_PORTS-1:0] wb_tag,
    output logic                      iss1_valid,
    output logic [1:0]                iss1_cls,
    output logic [TAG_W-1:0]          iss1_src1,
    output logic [TAG_W-1:0]          iss1_src2,
    output logic [TAG_W-1:0]          iss1_dst,
    output logic [ID_W-1:0]           iss1_id,
    output logic                      iss2_valid,
    output logic [1:0]                iss2_cls,
    output logic [TAG_W-1:0]          iss2_src1,
    output logic [TAG_W-1:0]          iss2_src2,
    output logic [TAG_W-1:0]          iss2_dst,
    output logic [ID_W-1:0]           iss2_id
);
    iq_op_t                      lane_op [LANES];
    logic   [LANES-1:0]          lane_act;
    logic   [LANES-1:0][DEPTH-1:0] grant;
    logic   [DEPTH-1:0]          free_mask, ready, pick1, pick2;
    logic   [DEPTH-1:0]          wr_en, wr_rdy1, wr_rdy2;
    iq_op_t                      wr_op [DEPTH];
    iq_op_t                      ent_op [DEPTH];
    logic   [2*DEPTH-1:0]        ent_cls;
    iq_op_t                      sel1, sel2;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_act[l]     = NUM_W'(l) < disp_num;
            lane_op[l].cls  = op_cls_e'(disp_cls[2*l +: 2]);
            lane_op[l].src1 = disp_src1[TAG_W*l +: TAG_W];
            lane_op[l].src2 = disp_src2[TAG_W*l +: TAG_W];
            lane_op[l].dst  = disp_dst[TAG_W*l +: TAG_W];
            lane_op[l].id   = disp_id[ID_W*l +: ID_W];
        end
    end

    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < DEPTH; i++) free_cnt = free_cnt + CNT_W'(free_mask[i]);
    end

    assign disp_accept = !flush && (CNT_W'(disp_num) <= free_cnt);

    iq_alloc #(.DEPTH(DEPTH), .LANES(LANES)) i_alloc (
        .free_mask (free_mask),
        .grant     (grant)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            wr_en[i]   = 1'b0;
            wr_op[i]   = '0;
            wr_rdy1[i] = 1'b0;
            wr_rdy2[i] = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                if (lane_act[l] && grant[l][i]) begin
                    wr_en[i]   = disp_accept;
                    wr_op[i]   = lane_op[l];
                    wr_rdy1[i] = disp_rdy1[l];
                    wr_rdy2[i] = disp_rdy2[l];
                end
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        iq_entry #(.WB(WB_PORTS)) i_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (wr_en[i]),
            .wr_op    (wr_op[i]),
            .wr_rdy1  (wr_rdy1[i]),
            .wr_rdy2  (wr_rdy2[i]),
            .wb_valid (wb_valid),
            .wb_tag   (wb_tag),
            .issue    (pick1[i] | pick2[i]),
            .is_free  (free_mask[i]),
            .is_ready (ready[i]),
            .op_q     (ent_op[i])
        );
        assign ent_cls[2*i +: 2] = ent_op[i].cls;
    end

    iq_select #(.DEPTH(DEPTH)) i_select (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready),
        .cls   (ent_cls),
        .pick1 (pick1),
        .pick2 (pick2)
    );

    always_comb begin
        sel1 = '0;
        sel2 = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pick1[i]) sel1 = ent_op[i];
            if (pick2[i]) sel2 = ent_op[i];
        end
    end

    assign iss1_valid = (|pick1) && !flush;
    assign iss1_cls   = sel1.cls;
    assign iss1_src1  = sel1.src1;
    assign iss1_src2  = sel1.src2;
    assign iss1_dst   = sel1.dst;
    assign iss1_id    = sel1.id;
    assign iss2_valid = (|pick2) && !flush;
    assign iss2_cls   = sel2.cls;
    assign iss2_src1  = sel2.src1;
    assign iss2_src2  = sel2.src2;
    assign iss2_dst   = sel2.dst;
    assign iss2_id    = sel2.id;

    AST_UNIT1_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> iss1_cls != CLS_MULDIV); // R7
    AST_UNIT2_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        iss2_valid |-> (iss2_cls != CLS_BRANCH && iss2_cls != CLS_SHIFT)); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> free_cnt == CNT_W'(DEPTH)); // R11
    AST_REFUSE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_accept && !flush) |=> free_cnt >= $past(free_cnt)); // R3
endmodule

// File: tb/test_int_issue_queue.sv
module test_int_issue_queue;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush;
    logic [2:0]  disp_num;
    logic [7:0]  disp_cls;
    logic [23:0] disp_src1, disp_src2, disp_dst;
    logic [3:0]  disp_rdy1, disp_rdy2;
    logic [19:0] disp_id;
    logic        disp_accept;
    logic [4:0]  free_cnt;
    logic [2:0]  wb_valid;
    logic [17:0] wb_tag;
    logic        iss1_valid, iss2_valid;
    logic [1:0]  iss1_cls, iss2_cls;
    logic [5:0]  iss1_src1, iss1_src2, iss1_dst, iss2_src1, iss2_src2, iss2_dst;
    logic [4:0]  iss1_id, iss2_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_issue_queue i_int_issue_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush), .disp_num(disp_num),
        .disp_cls(disp_cls), .disp_src1(disp_src1), .disp_src2(disp_src2),
        .disp_rdy1(disp_rdy1), .disp_rdy2(disp_rdy2), .disp_dst(disp_dst),
        .disp_id(disp_id), .disp_accept(disp_accept), .free_cnt(free_cnt),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .iss1_valid(iss1_valid), .iss1_cls(iss1_cls), .iss1_src1(iss1_src1),
        .iss1_src2(iss1_src2), .iss1_dst(iss1_dst), .iss1_id(iss1_id),
        .iss2_valid(iss2_valid), .iss2_cls(iss2_cls), .iss2_src1(iss2_src1),
        .iss2_src2(iss2_src2), .iss2_dst(iss2_dst), .iss2_id(iss2_id)
    );

    int checks = 0;
    int errors = 0;

    logic       m_val [N];
    logic [1:0] m_cls [N];
    logic [5:0] m_s1 [N], m_s2 [N], m_d [N];
    logic [4:0] m_id [N];
    logic       m_r1 [N], m_r2 [N];

    int   e_free, p1, p2;
    logic e_acc, e_v1, e_v2;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic hit(input logic [5:0] t);
        logic h = 1'b0;
        for (int k = 0; k < 3; k++)
            if (wb_valid[k] && wb_tag[6*k +: 6] == t) h = 1'b1;
        return h;
    endfunction

    task automatic idle();
        flush = 1'b0; disp_num = 3'd0; wb_valid = 3'b000;
    endtask

    task automatic set_lane(input int l, input logic [1:0] c, input logic [5:0] a, input logic [5:0] b,
                            input logic ra, input logic rb, input logic [5:0] d, input logic [4:0] id);
        disp_cls[2*l +: 2] = c;
        disp_src1[6*l +: 6] = a;
        disp_src2[6*l +: 6] = b;
        disp_rdy1[l] = ra;
        disp_rdy2[l] = rb;
        disp_dst[6*l +: 6] = d;
        disp_id[5*l +: 5] = id;
    endtask

    task automatic evaluate();
        e_free = 0;
        for (int i = 0; i < N; i++) if (!m_val[i]) e_free++;
        e_acc = !flush && (int'(disp_num) <= e_free);
        p1 = -1; p2 = -1;
        for (int i = 0; i < N; i++)
            if (p1 < 0 && m_val[i] && m_r1[i] && m_r2[i] && m_cls[i] != 2'd3) p1 = i;
        for (int i = 0; i < N; i++)
            if (p2 < 0 && i != p1 && m_val[i] && m_r1[i] && m_r2[i] && m_cls[i] != 2'd1 && m_cls[i] != 2'd2) p2 = i;
        e_v1 = (p1 >= 0) && !flush;
        e_v2 = (p2 >= 0) && !flush;
    endtask

    task automatic update_model();
        logic pre [N];
        logic taken [N];
        for (int i = 0; i < N; i++) begin pre[i] = m_val[i]; taken[i] = 1'b0; end
        if (flush) begin
            for (int i = 0; i < N; i++) m_val[i] = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) if (m_val[i]) begin
                m_r1[i] = m_r1[i] | hit(m_s1[i]);
                m_r2[i] = m_r2[i] | hit(m_s2[i]);
            end
            if (p1 >= 0) m_val[p1] = 1'b0;
            if (p2 >= 0) m_val[p2] = 1'b0;
            if (e_acc) begin
                for (int l = 0; l < int'(disp_num); l++) begin
                    int s = -1;
                    for (int i = 0; i < N; i++) if (s < 0 && !pre[i] && !taken[i]) s = i;
                    taken[s] = 1'b1;
                    m_val[s] = 1'b1;
                    m_cls[s] = disp_cls[2*l +: 2];
                    m_s1[s]  = disp_src1[6*l +: 6];
                    m_s2[s]  = disp_src2[6*l +: 6];
                    m_d[s]   = disp_dst[6*l +: 6];
                    m_id[s]  = disp_id[5*l +: 5];
                    m_r1[s]  = disp_rdy1[l] | hit(m_s1[s]);
                    m_r2[s]  = disp_rdy2[l] | hit(m_s2[s]);
                end
            end
        end
    endtask

    task automatic step(input string tag);
        #1;
        evaluate();
        chk("R2", 32'(free_cnt), 32'(e_free), "free_cnt");
        chk("R3", 32'(disp_accept), 32'(e_acc), "disp_accept");
        chk(tag, 32'(iss1_valid), 32'(e_v1), "iss1_valid");
        chk(tag, 32'(iss2_valid), 32'(e_v2), "iss2_valid");
        if (e_v1)
            chk("R10", {7'd0, iss1_cls, iss1_src1, iss1_src2, iss1_dst, iss1_id},
                {7'd0, m_cls[p1], m_s1[p1], m_s2[p1], m_d[p1], m_id[p1]}, "iss1 fields");
        if (e_v2)
            chk("R10", {7'd0, iss2_cls, iss2_src1, iss2_src2, iss2_dst, iss2_id},
                {7'd0, m_cls[p2], m_s1[p2], m_s2[p2], m_d[p2], m_id[p2]}, "iss2 fields");
        update_model();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < N; i++) begin
            m_val[i] = 1'b0; m_r1[i] = 1'b0; m_r2[i] = 1'b0;
            m_cls[i] = '0; m_s1[i] = '0; m_s2[i] = '0; m_d[i] = '0; m_id[i] = '0;
        end
        idle();
        disp_cls = '0; disp_src1 = '0; disp_src2 = '0; disp_dst = '0;
        disp_rdy1 = '0; disp_rdy2 = '0; disp_id = '0; wb_tag = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", 32'(free_cnt), 32'd16, "free_cnt after reset");
        chk("R1", 32'(iss1_valid), 32'd0, "iss1_valid after reset");
        chk("R1", 32'(iss2_valid), 32'd0, "iss2_valid after reset");
        @(negedge clk);

        // R6: branch and shift only on unit 1
        disp_num = 3'd2;
        set_lane(0, 2'd1, 6'd1, 6'd2, 1'b1, 1'b1, 6'd30, 5'd1);
        set_lane(1, 2'd2, 6'd3, 6'd4, 1'b1, 1'b1, 6'd31, 5'd2);
        step("R6");
        step("R6");
        chk("R6", 32'(iss1_valid), 32'd1, "shift left on unit 1");
        chk("R6", 32'(iss2_valid), 32'd0, "unit 2 idle for shift");
        step("R6");

        // R7: multiply/divide only on unit 2
        disp_num = 3'd2;
        set_lane(0, 2'd3, 6'd1, 6'd2, 1'b1, 1'b1, 6'd32, 5'd3);
        set_lane(1, 2'd3, 6'd3, 6'd4, 1'b1, 1'b1, 6'd33, 5'd4);
        step("R7");
        #1;
        chk("R7", 32'(iss1_valid), 32'd0, "unit 1 idle for mul/div");
        chk("R7", 32'(iss2_id), 32'd3, "first mul/div on unit 2");
        step("R7");
        step("R7");

        // R4 and R8: four ready ALU operations
        disp_num = 3'd4;
        for (int l = 0; l < 4; l++)
            set_lane(l, 2'd0, 6'd5, 6'd6, 1'b1, 1'b1, 6'(40 + l), 5'(8 + l));
        step("R4");
        #1;
        chk("R8", 32'(iss1_id), 32'd8, "unit 1 lowest slot");
        chk("R8", 32'(iss2_id), 32'd9, "unit 2 next slot");
        step("R8");
        step("R8");

        // R5: wakeup while held, and wakeup in the dispatch cycle
        disp_num = 3'd1;
        set_lane(0, 2'd0, 6'd9, 6'd6, 1'b0, 1'b1, 6'd44, 5'd16);
        step("R5");
        step("R5");
        wb_valid = 3'b100; wb_tag = {6'd9, 6'd0, 6'd0};
        step("R5");
        step("R5");
        disp_num = 3'd1;
        set_lane(0, 2'd0, 6'd6, 6'd12, 1'b1, 1'b0, 6'd45, 5'd17);
        wb_valid = 3'b010; wb_tag = {6'd0, 6'd12, 6'd0};
        step("R5");
        step("R5");

        // R3: fill all slots with waiting operations, then offer one more
        for (int b = 0; b < 4; b++) begin
            disp_num = 3'd4;
            for (int l = 0; l < 4; l++)
                set_lane(l, 2'(l), 6'd20, 6'd20, 1'b0, 1'b0, 6'(b*4 + l), 5'(b*4 + l));
            step("R3");
        end
        disp_num = 3'd1;
        set_lane(0, 2'd0, 6'd1, 6'd1, 1'b1, 1'b1, 6'd50, 5'd20);
        step("R3");
        #1;
        chk("R3", 32'(free_cnt), 32'd0, "full pool unchanged after refusal");

        // R9: one broadcast wakes all; drain two per cycle
        wb_valid = 3'b001; wb_tag = {6'd0, 6'd0, 6'd20};
        step("R9");
        for (int c = 0; c < 10; c++) step("R9");

        // R11: flush with held entries and a pending dispatch
        disp_num = 3'd2;
        set_lane(0, 2'd0, 6'd7, 6'd7, 1'b0, 1'b0, 6'd51, 5'd21);
        set_lane(1, 2'd0, 6'd7, 6'd7, 1'b1, 1'b1, 6'd52, 5'd22);
        step("R11");
        flush = 1'b1; disp_num = 3'd2;
        step("R11");
        #1;
        chk("R11", 32'(free_cnt), 32'd16, "free_cnt after flush");
        step("R11");

        // random traffic
        for (int c = 0; c < 3000; c++) begin
            flush = ($urandom % 64) == 0;
            disp_num = 3'($urandom % 5);
            for (int l = 0; l < 4; l++)
                set_lane(l, 2'($urandom % 4), 6'($urandom % 16), 6'($urandom % 16),
                         1'($urandom % 2), 1'($urandom % 2), 6'($urandom), 5'($urandom));
            wb_valid = 3'($urandom);
            for (int k = 0; k < 3; k++) wb_tag[6*k +: 6] = 6'($urandom % 16);
            step("R10");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule